// File: doc/BRIEF.md
# Token-Flow Logic Cell

This block is one cell of a fabric in which data moves as single-bit tokens, run here from an ordinary clock. Each of the cell's six neighbour faces has an incoming slot and an outgoing slot. A slot is either empty or holds a 0 or a 1. A configuration names up to two input faces (A and B), an output mask over the six faces, and a function. The cell fires only when every input it uses holds a token and every output it drives is empty.

When the cell fires, it takes tokens from its inputs with a one-cycle take strobe. The result lands in the selected outgoing slots on the next clock edge. A slot keeps its token until the neighbour downstream takes it. The cell can compute a gate (AND, NAND, OR, XOR), forward a token, cross two streams, copy under a control token, or discard tokens. Cells are chained by wiring one cell's outgoing slot and take input to the neighbour's incoming slot and take output.

Top module: `tok_cell`

## Requirements
- R1: While reset is asserted and after it is released, every outgoing slot is empty and no take strobe is raised. The reset configuration has no inputs, so the cell never fires until a configuration is loaded.
- R2: A cycle with `cfg_we_i` high loads the function, input A, input B and mask, and nothing fires in that cycle. The new configuration governs from the next cycle. Function codes: 0 AND, 1 NAND, 2 OR, 3 XOR, 4 forward, 5 crossover, 6 copy, 7 discard.
- R3: Input direction codes 0 to 5 select faces 0 to 5, and codes 6 and 7 mean the input is unused. Mask bit f selects outgoing face f. A take strobe is raised only on a face that is a configured input.
- R4: A take strobe is raised only on a face whose incoming slot holds a token. It is raised combinationally in the cycle the cell fires. The result shows in the outgoing slots after the next rising edge.
- R5: The cell fires only when every used input is full and every masked outgoing slot is empty. Otherwise it takes nothing and loads nothing. A new token appears only on a masked face.
- R6: The gate functions write f(A,B) to every masked face and take both inputs. When B is unused, A stands in for B, so one-input NAND inverts A.
- R7: Forward takes input A and copies it to every masked face. It ignores input B and leaves it untaken.
- R8: Crossover sends A to the masked faces 0 to 2 and B to the masked faces 3 to 5. The two paths are independent, each firing on its own input and its own group being empty.
- R9: Copy waits for both A and B. It writes A to the masked faces and takes B only, so the A token stays in place.
- R10: Discard takes all used inputs once they are full and never loads an outgoing slot.
- R11: An outgoing slot keeps its value until the take input for that face is high at a clock edge, and then it empties. A take on an empty slot has no effect.
- R12: In a chain of two forwarding cells under random injection and random back-pressure, every injected token arrives once, in order, with its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_func_i | input | 3 | Function code |
| cfg_ina_i | input | 3 | Input A direction code |
| cfg_inb_i | input | 3 | Input B direction code |
| cfg_mask_i | input | 6 | Output face mask |
| in_vld_i | input | 6 | Incoming slot holds a token, per face |
| in_dat_i | input | 6 | Incoming token value, per face |
| in_take_o | output | 6 | Incoming token consumed this cycle, per face |
| out_vld_o | output | 6 | Outgoing slot holds a token, per face |
| out_dat_o | output | 6 | Outgoing token value, per face |
| out_take_i | input | 6 | Neighbour consumes the outgoing token, per face |

## Verification
The hardest case to reach is the crossover path that fires alone while the other group stays blocked. The bench gets there by draining only the low-group face and then offering new tokens on both inputs. Only A must be taken, and B is taken later, once its own face is drained. Loss or duplication in a chain only shows up when stalls fall at awkward moments. A scoreboard queue is filled at injection and emptied at the far output, under random back-pressure, and is drained to empty at the end.

// File: rtl/tok_cell_pkg.sv
package tok_cell_pkg;

  typedef enum logic [2:0] {
    FN_AND   = 3'd0,
    FN_NAND  = 3'd1,
    FN_OR    = 3'd2,
    FN_XOR   = 3'd3,
    FN_WIRE  = 3'd4,
    FN_XOVER = 3'd5,
    FN_COPY  = 3'd6,
    FN_DEL   = 3'd7
  } fn_e;

  function automatic logic gate_eval(fn_e fn, logic a, logic b);
    case (fn)
      FN_AND:  return a & b;
      FN_NAND: return ~(a & b);
      FN_OR:   return a | b;
      FN_XOR:  return a ^ b;
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/tok_cell_cfg.sv
module tok_cell_cfg
  import tok_cell_pkg::*;
#(
  parameter int NFACE = 6,
  parameter int DIRW  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       func_i,
  input  logic [DIRW-1:0]  ina_i,
  input  logic [DIRW-1:0]  inb_i,
  input  logic [NFACE-1:0] mask_i,
  output fn_e              fn_o,
  output logic [DIRW-1:0]  ina_o,
  output logic [DIRW-1:0]  inb_o,
  output logic [NFACE-1:0] mask_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_o   <= FN_DEL;
      ina_o  <= '1;  // all-ones code is "unused"
      inb_o  <= '1;
      mask_o <= '0;
    end else if (we_i) begin
      fn_o   <= fn_e'(func_i);
      ina_o  <= ina_i;
      inb_o  <= inb_i;
      mask_o <= mask_i;
    end
  end

endmodule

// File: rtl/tok_cell_fire.sv
module tok_cell_fire
  import tok_cell_pkg::*;
#(
  parameter int NFACE = 6,
  parameter int DIRW  = 3
) (
  input  logic             hold_i,
  input  fn_e              fn_i,
  input  logic [DIRW-1:0]  ina_i,
  input  logic [DIRW-1:0]  inb_i,
  input  logic [NFACE-1:0] mask_i,
  input  logic [NFACE-1:0] in_vld_i,
  input  logic [NFACE-1:0] in_dat_i,
  input  logic [NFACE-1:0] slot_vld_i,
  output logic [NFACE-1:0] in_take_o,
  output logic [NFACE-1:0] ld_o,
  output logic [NFACE-1:0] ld_dat_o
);

  localparam int HALF = NFACE / 2;
  localparam logic [NFACE-1:0] LO_M = NFACE'((1 << HALF) - 1);

  logic [NFACE-1:0] a_sel, b_sel;

  for (genvar f = 0; f < NFACE; f++) begin : g_sel
    assign a_sel[f] = (ina_i == DIRW'(f));
    assign b_sel[f] = (inb_i == DIRW'(f));
  end

  logic a_used, b_used, a_v, b_v, a_d, b_d, b_op;
  logic free_all, free_lo, free_hi;
  logic take_a, take_b;

  assign a_used = |a_sel;
  assign b_used = |b_sel;
  assign a_v    = |(a_sel & in_vld_i);
  assign b_v    = |(b_sel & in_vld_i);
  assign a_d    = |(a_sel & in_dat_i);
  assign b_d    = |(b_sel & in_dat_i);
  assign b_op   = b_used ? b_d : a_d;

  assign free_all = ~|(mask_i & slot_vld_i);
  assign free_lo  = ~|(mask_i & LO_M & slot_vld_i);
  assign free_hi  = ~|(mask_i & ~LO_M & slot_vld_i);

  always_comb begin
    take_a   = 1'b0;
    take_b   = 1'b0;
    ld_o     = '0;
    ld_dat_o = '0;
    if (!hold_i) begin
      case (fn_i)
        FN_AND, FN_NAND, FN_OR, FN_XOR: begin
          if (a_v && (!b_used || b_v) && free_all) begin
            take_a   = 1'b1;
            take_b   = b_used;
            ld_o     = mask_i;
            ld_dat_o = {NFACE{gate_eval(fn_i, a_d, b_op)}};
          end
        end
        FN_WIRE: begin
          if (a_v && free_all) begin
            take_a   = 1'b1;
            ld_o     = mask_i;
            ld_dat_o = {NFACE{a_d}};
          end
        end
        FN_XOVER: begin
          if (a_v && free_lo) begin
            take_a   = 1'b1;
            ld_o     = ld_o | (mask_i & LO_M);
            ld_dat_o = ld_dat_o | ({NFACE{a_d}} & LO_M);
          end
          if (b_v && free_hi) begin
            take_b   = 1'b1;
            ld_o     = ld_o | (mask_i & ~LO_M);
            ld_dat_o = ld_dat_o | ({NFACE{b_d}} & ~LO_M);
          end
        end
        FN_COPY: begin
          // A is data and stays; B is the control token and is consumed
          if (a_v && b_v && free_all) begin
            take_b   = 1'b1;
            ld_o     = mask_i;
            ld_dat_o = {NFACE{a_d}};
          end
        end
        default: begin
          if ((a_used || b_used) && (!a_used || a_v) && (!b_used || b_v)) begin
            take_a = a_used;
            take_b = b_used;
          end
        end
      endcase
    end
  end

  assign in_take_o = ({NFACE{take_a}} & a_sel) | ({NFACE{take_b}} & b_sel);

endmodule

// File: rtl/tok_cell_slots.sv
module tok_cell_slots #(
  parameter int NFACE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFACE-1:0] ld_i,
  input  logic [NFACE-1:0] ld_dat_i,
  input  logic [NFACE-1:0] take_i,
  output logic [NFACE-1:0] vld_o,
  output logic [NFACE-1:0] dat_o
);

  for (genvar f = 0; f < NFACE; f++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[f] <= 1'b0;
        dat_o[f] <= 1'b0;
      end else if (ld_i[f]) begin
        vld_o[f] <= 1'b1;
        dat_o[f] <= ld_dat_i[f];
      end else if (take_i[f]) begin
        vld_o[f] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tok_cell.sv
module tok_cell
  import tok_cell_pkg::*;
#(
  parameter int NFACE = 6,
  localparam int DIRW = $clog2(NFACE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_func_i,
  input  logic [DIRW-1:0]  cfg_ina_i,
  input  logic [DIRW-1:0]  cfg_inb_i,
  input  logic [NFACE-1:0] cfg_mask_i,
  input  logic [NFACE-1:0] in_vld_i,
  input  logic [NFACE-1:0] in_dat_i,
  output logic [NFACE-1:0] in_take_o,
  output logic [NFACE-1:0] out_vld_o,
  output logic [NFACE-1:0] out_dat_o,
  input  logic [NFACE-1:0] out_take_i
);

  fn_e              cfg_fn;
  logic [DIRW-1:0]  cfg_ina, cfg_inb;
  logic [NFACE-1:0] cfg_mask;
  logic [NFACE-1:0] ld, ld_dat;

  tok_cell_cfg #(.NFACE(NFACE), .DIRW(DIRW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .func_i (cfg_func_i),
    .ina_i  (cfg_ina_i),
    .inb_i  (cfg_inb_i),
    .mask_i (cfg_mask_i),
    .fn_o   (cfg_fn),
    .ina_o  (cfg_ina),
    .inb_o  (cfg_inb),
    .mask_o (cfg_mask)
  );

  tok_cell_fire #(.NFACE(NFACE), .DIRW(DIRW)) u_fire (
    .hold_i     (cfg_we_i),
    .fn_i       (cfg_fn),
    .ina_i      (cfg_ina),
    .inb_i      (cfg_inb),
    .mask_i     (cfg_mask),
    .in_vld_i   (in_vld_i),
    .in_dat_i   (in_dat_i),
    .slot_vld_i (out_vld_o),
    .in_take_o  (in_take_o),
    .ld_o       (ld),
    .ld_dat_o   (ld_dat)
  );

  tok_cell_slots #(.NFACE(NFACE)) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .ld_dat_i (ld_dat),
    .take_i   (out_take_i),
    .vld_o    (out_vld_o),
    .dat_o    (out_dat_o)
  );

endmodule

// File: rtl/tok_cell_chk.sv
module tok_cell_chk
  import tok_cell_pkg::*;
#(
  parameter int NFACE = 6,
  parameter int DIRW  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input fn_e              fn_i,
  input logic [DIRW-1:0]  ina_i,
  input logic [DIRW-1:0]  inb_i,
  input logic [NFACE-1:0] mask_i,
  input logic [NFACE-1:0] in_vld_i,
  input logic [NFACE-1:0] in_take_o,
  input logic [NFACE-1:0] out_vld_o,
  input logic [NFACE-1:0] out_dat_o,
  input logic [NFACE-1:0] out_take_i
);

  logic [NFACE-1:0] a_sel, b_sel, held;

  for (genvar f = 0; f < NFACE; f++) begin : g_sel
    assign a_sel[f] = (ina_i == DIRW'(f));
    assign b_sel[f] = (inb_i == DIRW'(f));
  end

  assign held = out_vld_o & ~out_take_i;

  assert_hold_on_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> in_take_o == '0);

  assert_take_cfg_face_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_take_o & ~(a_sel | b_sel)) == '0);

  assert_take_needs_token_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_take_o & ~in_vld_i) == '0);

  assert_new_token_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (out_vld_o & ~$past(out_vld_o) & ~$past(mask_i)) == '0);

  assert_copy_keeps_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == FN_COPY && ina_i != inb_i) |-> (in_take_o & a_sel) == '0);

  assert_delete_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == FN_DEL && !cfg_we_i) |=> (out_vld_o & ~$past(out_vld_o)) == '0);

  assert_slot_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((out_vld_o & $past(held)) == $past(held)) &&
             ((out_dat_o & $past(held)) == ($past(out_dat_o) & $past(held))));

  assert_slot_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (out_vld_o & $past(out_vld_o & out_take_i)) == '0);

endmodule

bind tok_cell tok_cell_chk #(.NFACE(NFACE), .DIRW(DIRW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .fn_i       (cfg_fn),
  .ina_i      (cfg_ina),
  .inb_i      (cfg_inb),
  .mask_i     (cfg_mask),
  .in_vld_i   (in_vld_i),
  .in_take_o  (in_take_o),
  .out_vld_o  (out_vld_o),
  .out_dat_o  (out_dat_o),
  .out_take_i (out_take_i)
);

// File: tb/tok_cell_test.sv
module tok_cell_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // cell under test
  logic       a_we;
  logic [2:0] a_fn, a_ina, a_inb;
  logic [5:0] a_mask, a_vld, a_dat, a_take, a_ovld, a_odat, tb_take_a, a_otake;
  // downstream cell, fed from face 0 of uut into its face 3
  logic       b_we;
  logic [2:0] b_fn, b_ina, b_inb;
  logic [5:0] b_mask, b_vld, b_dat, b_take, b_ovld, b_odat, tb_take_b;

  assign a_otake = tb_take_a | {5'b0, b_take[3]};
  assign b_vld   = {2'b0, a_ovld[0], 3'b0};
  assign b_dat   = {2'b0, a_odat[0], 3'b0};

  tok_cell uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(a_we), .cfg_func_i(a_fn),
    .cfg_ina_i(a_ina), .cfg_inb_i(a_inb), .cfg_mask_i(a_mask),
    .in_vld_i(a_vld), .in_dat_i(a_dat), .in_take_o(a_take),
    .out_vld_o(a_ovld), .out_dat_o(a_odat), .out_take_i(a_otake)
  );

  tok_cell uut2 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(b_we), .cfg_func_i(b_fn),
    .cfg_ina_i(b_ina), .cfg_inb_i(b_inb), .cfg_mask_i(b_mask),
    .in_vld_i(b_vld), .in_dat_i(b_dat), .in_take_o(b_take),
    .out_vld_o(b_ovld), .out_dat_o(b_odat), .out_take_i(tb_take_b)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg_a(logic [2:0] fn, logic [2:0] ia, logic [2:0] ib, logic [5:0] m);
    a_we = 1'b1; a_fn = fn; a_ina = ia; a_inb = ib; a_mask = m;
    step();
    a_we = 1'b0;
  endtask

  task automatic cfg_b(logic [2:0] fn, logic [2:0] ia, logic [2:0] ib, logic [5:0] m);
    b_we = 1'b1; b_fn = fn; b_ina = ia; b_inb = ib; b_mask = m;
    step();
    b_we = 1'b0;
  endtask

  task automatic drain_a();
    tb_take_a = 6'b111110;
    step();
    tb_take_a = '0;
  endtask

  function automatic logic gate_ref(int f, logic a, logic b);
    case (f)
      0: return a & b;
      1: return ~(a & b);
      2: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  bit done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int q[$];
    a_we = 0; a_fn = 0; a_ina = 0; a_inb = 0; a_mask = 0; a_vld = 0; a_dat = 0; tb_take_a = 0;
    b_we = 0; b_fn = 0; b_ina = 0; b_inb = 0; b_mask = 0; tb_take_b = 0;
    #5;
    chk("R1 reset slots", a_ovld, 0);
    chk("R1 reset take", a_take, 0);
    #40 rst_n = 1'b1;
    step();
    // reset config: offered tokens are never taken
    a_vld = 6'b111111;
    #1 chk("R1 idle take", a_take, 0);
    step();
    chk("R1 idle slots", a_ovld, 0);
    a_vld = '0;

    // R6 gate truth tables, A on face 4, B on face 5, outputs faces 1 and 2
    for (int f = 0; f < 4; f++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic av, bv, e;
        av = ab[0]; bv = ab[1];
        e = gate_ref(f, av, bv);
        cfg_a(3'(f), 3'd4, 3'd5, 6'b000110);
        a_vld = 6'b110000; a_dat = {bv, av, 4'b0};
        #1 chk("R4 gate take", a_take, 6'h30);
        step();
        a_vld = '0;
        chk("R6 gate valid", a_ovld, 6'b000110);
        chk("R6 gate data", a_odat & 6'b000110, e ? 6'b000110 : 0);
        drain_a();
        chk("R11 drained", a_ovld, 0);
      end
    end

    // R5 firing waits for all inputs and empty outputs
    cfg_a(3'd0, 3'd4, 3'd5, 6'b000010);
    a_vld = 6'b010000; a_dat = 6'b110000;
    #1 chk("R5 half input take", a_take, 0);
    step();
    chk("R5 half input slots", a_ovld, 0);
    a_vld = 6'b110000;
    step();
    a_vld = '0;
    chk("R5 fired", a_ovld, 6'b000010);
    a_vld = 6'b110000; a_dat = 6'b000000;
    #1 chk("R5 output full take", a_take, 0);
    step();
    chk("R11 slot kept", a_odat, 6'b000010);
    drain_a();
    #1 chk("R5 fires after drain", a_take, 6'h30);
    step();
    a_vld = '0;
    chk("R6 and 0,0", a_odat & 6'b000010, 0);
    drain_a();

    // R3 unused codes 6 and 7 never fire
    cfg_a(3'd0, 3'd6, 3'd7, 6'b000010);
    a_vld = 6'b111111;
    #1 chk("R3 unused take", a_take, 0);
    step();
    a_vld = '0;
    chk("R3 unused slots", a_ovld, 0);

    // R6 one-input NAND inverts
    cfg_a(3'd1, 3'd4, 3'd7, 6'b000010);
    a_vld = 6'b010000; a_dat = 6'b010000;
    #1 chk("R6 single take", a_take, 6'b010000);
    step();
    a_vld = '0;
    chk("R6 single nand", a_ovld & ~a_odat, 6'b000010);
    drain_a();

    // R7 forward ignores B
    cfg_a(3'd4, 3'd4, 3'd5, 6'b000100);
    a_vld = 6'b110000; a_dat = 6'b010000;
    #1 chk("R7 wire take", a_take, 6'b010000);
    step();
    a_vld = '0;
    chk("R7 wire out", a_ovld & a_odat, 6'b000100);
    drain_a();

    // R8 crossover, face 1 low group, face 3 high group
    cfg_a(3'd5, 3'd4, 3'd5, 6'b001010);
    a_vld = 6'b110000; a_dat = 6'b010000;
    #1 chk("R8 both take", a_take, 6'b110000);
    step();
    a_vld = '0;
    chk("R8 both valid", a_ovld, 6'b001010);
    chk("R8 both data", a_odat & 6'b001010, 6'b000010);
    tb_take_a = 6'b000010;
    step();
    tb_take_a = '0;
    a_vld = 6'b110000; a_dat = 6'b100000;
    #1 chk("R8 independent take", a_take, 6'b010000);
    step();
    a_vld = 6'b100000;
    chk("R8 low reloaded", a_ovld, 6'b001010);
    chk("R8 low data", a_odat & 6'b001010, 0);
    drain_a();
    #1 chk("R8 high take later", a_take, 6'b100000);
    step();
    a_vld = '0;
    chk("R8 high data", a_ovld & a_odat, 6'b001000);
    drain_a();

    // R9 copy consumes only B
    cfg_a(3'd6, 3'd4, 3'd5, 6'b000010);
    a_vld = 6'b110000; a_dat = 6'b010000;
    #1 chk("R9 copy take", a_take, 6'b100000);
    step();
    a_vld = 6'b010000;
    chk("R9 copy out", a_ovld & a_odat, 6'b000010);
    #1 chk("R9 waits for B", a_take, 0);
    a_vld = '0;
    step();
    drain_a();

    // R10 discard
    cfg_a(3'd7, 3'd4, 3'd5, 6'b000110);
    a_vld = 6'b110000; a_dat = 6'b110000;
    #1 chk("R10 discard take", a_take, 6'b110000);
    step();
    a_vld = '0;
    chk("R10 discard silent", a_ovld, 0);

    // R2 config cycle holds firing, new config active next cycle
    a_vld = 6'b110000; a_dat = 6'b110000;
    a_we = 1'b1; a_fn = 3'd0; a_ina = 3'd4; a_inb = 3'd5; a_mask = 6'b000010;
    #1 chk("R2 hold during load", a_take, 0);
    step();
    a_we = 1'b0;
    #1 chk("R2 new config fires", a_take, 6'b110000);
    step();
    a_vld = '0;
    chk("R2 new config out", a_ovld & a_odat, 6'b000010);
    drain_a();

    // R11 take on empty slot
    tb_take_a = 6'b111110;
    step();
    tb_take_a = '0;
    chk("R11 empty take", a_ovld, 0);

    // R12 two-cell chain with scoreboard
    cfg_a(3'd4, 3'd4, 3'd7, 6'b000001);
    cfg_b(3'd4, 3'd3, 3'd7, 6'b000010);
    for (int c = 0; c < 700; c++) begin
      bit got_in, r, d;
      if (!a_vld[4] && c < 500) begin
        r = 1'($urandom_range(1, 0));
        if (r) begin
          d = 1'($urandom_range(1, 0));
          a_vld = 6'b010000; a_dat = {1'b0, d, 4'b0};
          q.push_back(int'(d));
        end
      end
      r = 1'($urandom_range(1, 0));
      tb_take_b = (c >= 500 || r) ? 6'b000010 : 6'b000000;
      #1;
      got_in = a_vld[4] & a_take[4];
      if (b_ovld[1] && tb_take_b[1]) begin
        if (q.size() == 0) chk("R12 duplicate token", 1, 0);
        else chk("R12 chain data", int'(b_odat[1]), q.pop_front());
      end
      step();
      if (got_in) a_vld = '0;
    end
    tb_take_b = '0;
    chk("R12 nothing lost", q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule